// File: doc/BRIEF.md
# Configurable Input Capture Register

This block is the storage stage that sits behind one input pin, replicated `WIDTH` times. A build-time mode parameter chooses what the stage does. It can be a rising-edge flip-flop or a level-sensitive latch that is open while the clock is high. It can be a plain wire with no storage. It can also be a double-data-rate sampler that takes one sample on each clock edge and presents the pair in one of three time alignments. A combinational copy of the input is always available beside the stored outputs.

Every storage element in the block shares one clock enable and two forcing requests. The first request drives the stored state to a build-time reset value. The second drives it to the inverse of that value. The first always wins when both are present. A second parameter decides whether the requests act at once (asynchronous) or only at the clock edge that owns each element (synchronous). Tie `clk_en` high for a stage that should capture on every edge.

Top module: `ioc_capture`

## Requirements
- R1: In FLOP mode (code 0), `cap_rise` takes `din` on each rising clock edge when `clk_en` is 1, and `cap_fall` stays at the reset pattern (every bit equal to RESET_VAL).
- R2: When `clk_en` is 0 and no forcing request is active, every storage element holds its value on every clock edge and clock level.
- R3: In LATCH mode (code 1), `cap_rise` follows `din` while `clk` is high and `clk_en` is 1, and holds the value present at the falling edge while `clk` is low; `cap_fall` stays at the reset pattern.
- R4: In COMB mode (code 2), `cap_rise` and `cap_fall` are constant at the reset pattern. In every mode, `din_thru` equals `din` with no clocking.
- R5: In DDR_OPP mode (code 3), `cap_rise` takes `din` on the rising edge and `cap_fall` takes `din` on the falling edge.
- R6: In DDR_SAME mode (code 4), both outputs change on the rising edge. After rising edge k, `cap_rise` holds the sample from edge k and `cap_fall` holds the falling-edge sample taken half a cycle earlier.
- R7: In DDR_PIPE mode (code 5), both outputs change on the rising edge and present the rising and falling samples of the same earlier clock period, one cycle late.
- R8: `rst_req` = 1 forces every storage element to the reset pattern.
- R9: `inv_req` = 1 with `rst_req` = 0 forces every storage element to the inverse of the reset pattern. When both are 1, the reset pattern wins.
- R10: With ASYNC_FORCE = 0, a forcing request only acts at each element's own clock event (rising edge, falling edge, or the high level for the latch), whatever `clk_en` is. Outputs do not move before that event.
- R11: With ASYNC_FORCE = 1, a forcing request changes the outputs immediately, without waiting for a clock edge.
- R12: After both requests return to 0, normal capture resumes in every mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Capture clock; both edges are used in the DDR modes |
| clk_en | input | 1 | Shared active-high enable for all storage elements |
| rst_req | input | 1 | Force storage to the reset pattern; highest priority |
| inv_req | input | 1 | Force storage to the inverse of the reset pattern |
| din | input | WIDTH | Data from the pins |
| cap_rise | output | WIDTH | Rising-edge (or latched) capture |
| cap_fall | output | WIDTH | Falling-edge capture in the DDR modes |
| din_thru | output | WIDTH | Combinational copy of `din` |

## Verification
The bench builds all six modes twice, once with an asynchronous reset value of 0 and once with a synchronous reset value of 1. It checks them together against a sample history that it keeps of the data present at each edge. A half-cycle slip in the same-edge or pipelined alignment would show up as `cap_fall` or `cap_rise` carrying a neighbouring sample. A latch built as a flop would fail the check made mid-high-phase after `din` changes. The forcing sequence goes set, then both, then reset alone. It catches a set that beats reset, a synchronous request that leaks through before the clock, and an asynchronous one that waits for an edge. A hold window with the enable low catches any element that ignores `clk_en`.

// File: rtl/ioc_pkg.sv
`timescale 1ns/1ps
package ioc_pkg;

    typedef enum logic [2:0] {
        IOC_FLOP     = 3'd0,
        IOC_LATCH    = 3'd1,
        IOC_COMB     = 3'd2,
        IOC_DDR_OPP  = 3'd3,
        IOC_DDR_SAME = 3'd4,
        IOC_DDR_PIPE = 3'd5
    } ioc_mode_e;

    function automatic bit is_ddr(ioc_mode_e m);
        return (m == IOC_DDR_OPP) || (m == IOC_DDR_SAME) || (m == IOC_DDR_PIPE);
    endfunction

endpackage

// File: rtl/ioc_edge_reg.sv
`timescale 1ns/1ps
module ioc_edge_reg #(
    parameter int unsigned WIDTH       = 1,
    parameter bit          RESET_VAL   = 1'b0,
    parameter bit          ASYNC_FORCE = 1'b0,
    parameter bit          FALLING     = 1'b0
) (
    input  logic             clk,
    input  logic             en,
    input  logic             rst_req,
    input  logic             inv_req,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] q
);
    localparam logic [WIDTH-1:0] RST_PAT = {WIDTH{RESET_VAL}};
    localparam logic [WIDTH-1:0] INV_PAT = ~RST_PAT;

    typedef struct packed {
        logic [WIDTH-1:0] val;
    } reg_t;

    reg_t st_d, st_q;

    // capture path only; forcing is applied in the register process
    always_comb begin
        st_d = st_q;
        if (en) begin
            st_d.val = din;
        end
    end

    generate
        if (ASYNC_FORCE && !FALLING) begin : g_async_rise
            always_ff @(posedge clk or posedge rst_req or posedge inv_req) begin
                if (rst_req)      st_q.val <= RST_PAT;
                else if (inv_req) st_q.val <= INV_PAT;
                else              st_q     <= st_d;
            end
        end else if (ASYNC_FORCE && FALLING) begin : g_async_fall
            always_ff @(negedge clk or posedge rst_req or posedge inv_req) begin
                if (rst_req)      st_q.val <= RST_PAT;
                else if (inv_req) st_q.val <= INV_PAT;
                else              st_q     <= st_d;
            end
        end else if (!FALLING) begin : g_sync_rise
            always_ff @(posedge clk) begin
                if (rst_req)      st_q.val <= RST_PAT;
                else if (inv_req) st_q.val <= INV_PAT;
                else              st_q     <= st_d;
            end
        end else begin : g_sync_fall
            always_ff @(negedge clk) begin
                if (rst_req)      st_q.val <= RST_PAT;
                else if (inv_req) st_q.val <= INV_PAT;
                else              st_q     <= st_d;
            end
        end
    endgenerate

    assign q = st_q.val;

endmodule

// File: rtl/ioc_level_latch.sv
`timescale 1ns/1ps
module ioc_level_latch #(
    parameter int unsigned WIDTH       = 1,
    parameter bit          RESET_VAL   = 1'b0,
    parameter bit          ASYNC_FORCE = 1'b0
) (
    input  logic             clk,
    input  logic             en,
    input  logic             rst_req,
    input  logic             inv_req,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] q
);
    localparam logic [WIDTH-1:0] RST_PAT = {WIDTH{RESET_VAL}};
    localparam logic [WIDTH-1:0] INV_PAT = ~RST_PAT;

    logic             force_d;
    logic [WIDTH-1:0] force_val_d;
    logic             open_d;
    logic [WIDTH-1:0] lat_q;

    always_comb begin
        // synchronous forcing only takes effect while the latch is open
        force_d     = (rst_req | inv_req) & (ASYNC_FORCE | clk);
        force_val_d = rst_req ? RST_PAT : INV_PAT;
        open_d      = clk & en;
    end

    always_latch begin
        if (force_d)     lat_q <= force_val_d;
        else if (open_d) lat_q <= din;
    end

    assign q = lat_q;

endmodule

// File: rtl/ioc_ddr_align.sv
`timescale 1ns/1ps
module ioc_ddr_align
    import ioc_pkg::*;
#(
    parameter int unsigned WIDTH       = 1,
    parameter bit          RESET_VAL   = 1'b0,
    parameter bit          ASYNC_FORCE = 1'b0,
    parameter ioc_mode_e   ALIGN       = IOC_DDR_OPP
) (
    input  logic             clk,
    input  logic             en,
    input  logic             rst_req,
    input  logic             inv_req,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] rise_o,
    output logic [WIDTH-1:0] fall_o
);
    logic [WIDTH-1:0] rise_s;
    logic [WIDTH-1:0] fall_s;

    ioc_edge_reg #(.WIDTH(WIDTH), .RESET_VAL(RESET_VAL), .ASYNC_FORCE(ASYNC_FORCE), .FALLING(1'b0)) u_rise (
        .clk(clk), .en(en), .rst_req(rst_req), .inv_req(inv_req), .din(din), .q(rise_s)
    );

    ioc_edge_reg #(.WIDTH(WIDTH), .RESET_VAL(RESET_VAL), .ASYNC_FORCE(ASYNC_FORCE), .FALLING(1'b1)) u_fall (
        .clk(clk), .en(en), .rst_req(rst_req), .inv_req(inv_req), .din(din), .q(fall_s)
    );

    generate
        if (ALIGN == IOC_DDR_OPP) begin : g_opp
            assign rise_o = rise_s;
            assign fall_o = fall_s;
        end else begin : g_retime
            // bring the falling sample onto the rising edge
            ioc_edge_reg #(.WIDTH(WIDTH), .RESET_VAL(RESET_VAL), .ASYNC_FORCE(ASYNC_FORCE), .FALLING(1'b0)) u_fall_rt (
                .clk(clk), .en(en), .rst_req(rst_req), .inv_req(inv_req), .din(fall_s), .q(fall_o)
            );
            if (ALIGN == IOC_DDR_PIPE) begin : g_pipe
                // delay the rising sample so both belong to one period
                ioc_edge_reg #(.WIDTH(WIDTH), .RESET_VAL(RESET_VAL), .ASYNC_FORCE(ASYNC_FORCE), .FALLING(1'b0)) u_rise_rt (
                    .clk(clk), .en(en), .rst_req(rst_req), .inv_req(inv_req), .din(rise_s), .q(rise_o)
                );
            end else begin : g_same
                assign rise_o = rise_s;
            end
        end
    endgenerate

endmodule

// File: rtl/ioc_capture.sv
`timescale 1ns/1ps
module ioc_capture
    import ioc_pkg::*;
#(
    parameter int unsigned WIDTH       = 1,
    parameter ioc_mode_e   MODE        = IOC_FLOP,
    parameter bit          RESET_VAL   = 1'b0,
    parameter bit          ASYNC_FORCE = 1'b0
) (
    input  logic             clk,
    input  logic             clk_en,
    input  logic             rst_req,
    input  logic             inv_req,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] cap_rise,
    output logic [WIDTH-1:0] cap_fall,
    output logic [WIDTH-1:0] din_thru
);
    localparam logic [WIDTH-1:0] RST_PAT = {WIDTH{RESET_VAL}};

    assign din_thru = din;

    generate
        if (MODE == IOC_FLOP) begin : g_flop
            ioc_edge_reg #(.WIDTH(WIDTH), .RESET_VAL(RESET_VAL), .ASYNC_FORCE(ASYNC_FORCE), .FALLING(1'b0)) u_reg (
                .clk(clk), .en(clk_en), .rst_req(rst_req), .inv_req(inv_req), .din(din), .q(cap_rise)
            );
            assign cap_fall = RST_PAT;
        end else if (MODE == IOC_LATCH) begin : g_latch
            ioc_level_latch #(.WIDTH(WIDTH), .RESET_VAL(RESET_VAL), .ASYNC_FORCE(ASYNC_FORCE)) u_lat (
                .clk(clk), .en(clk_en), .rst_req(rst_req), .inv_req(inv_req), .din(din), .q(cap_rise)
            );
            assign cap_fall = RST_PAT;
        end else if (is_ddr(MODE)) begin : g_ddr
            ioc_ddr_align #(.WIDTH(WIDTH), .RESET_VAL(RESET_VAL), .ASYNC_FORCE(ASYNC_FORCE), .ALIGN(MODE)) u_ddr (
                .clk(clk), .en(clk_en), .rst_req(rst_req), .inv_req(inv_req), .din(din),
                .rise_o(cap_rise), .fall_o(cap_fall)
            );
        end else begin : g_comb
            assign cap_rise = RST_PAT;
            assign cap_fall = RST_PAT;
        end
    endgenerate

endmodule

// File: rtl/ioc_capture_chk.sv
`timescale 1ns/1ps
module ioc_capture_chk
    import ioc_pkg::*;
#(
    parameter int unsigned WIDTH       = 1,
    parameter ioc_mode_e   MODE        = IOC_FLOP,
    parameter bit          RESET_VAL   = 1'b0,
    parameter bit          ASYNC_FORCE = 1'b0
) (
    input logic             clk,
    input logic             clk_en,
    input logic             rst_req,
    input logic             inv_req,
    input logic [WIDTH-1:0] din,
    input logic [WIDTH-1:0] cap_rise,
    input logic [WIDTH-1:0] cap_fall
);
    localparam logic [WIDTH-1:0] RST_PAT = {WIDTH{RESET_VAL}};
    localparam logic [WIDTH-1:0] INV_PAT = ~RST_PAT;
    localparam bit RISE_REG = (MODE == IOC_FLOP) || is_ddr(MODE);
    localparam bit RISE_NOW = (MODE == IOC_FLOP) || (MODE == IOC_DDR_OPP) || (MODE == IOC_DDR_SAME);

    generate
        if (RISE_REG) begin : g_rise
            AST_RST_FORCES_RISE: assert property (@(posedge clk) rst_req |=> cap_rise == RST_PAT) else $error("rst_req did not force cap_rise"); // R8
            AST_INV_FORCES_RISE: assert property (@(posedge clk) disable iff (rst_req) (!rst_req && inv_req) |=> cap_rise == INV_PAT) else $error("inv_req did not force cap_rise"); // R9
            AST_EN_LOW_HOLDS: assert property (@(posedge clk) disable iff (rst_req || inv_req) !clk_en |=> $stable(cap_rise)) else $error("cap_rise moved with enable low"); // R2
        end
        if (RISE_NOW) begin : g_now
            AST_RISE_TAKES_DIN: assert property (@(posedge clk) disable iff (rst_req || inv_req) (clk_en && !rst_req && !inv_req) |=> cap_rise == $past(din)) else $error("cap_rise missed din"); // R1
        end
        if (MODE == IOC_DDR_OPP) begin : g_opp
            AST_FALL_TAKES_DIN: assert property (@(negedge clk) disable iff (rst_req || inv_req) (clk_en && !rst_req && !inv_req) |=> cap_fall == $past(din)) else $error("cap_fall missed din"); // R5
        end
    endgenerate

endmodule

bind ioc_capture ioc_capture_chk #(
    .WIDTH(WIDTH), .MODE(MODE), .RESET_VAL(RESET_VAL), .ASYNC_FORCE(ASYNC_FORCE)
) u_chk (
    .clk(clk), .clk_en(clk_en), .rst_req(rst_req), .inv_req(inv_req),
    .din(din), .cap_rise(cap_rise), .cap_fall(cap_fall)
);

// File: tb/ioc_capture_tb.sv
`timescale 1ns/1ps
module ioc_capture_tb_top;
    localparam int W = 4;
    localparam int N = 12;

    logic         clk = 1'b0;
    logic         clk_en;
    logic         rst_req;
    logic         inv_req;
    logic [W-1:0] din;
    logic [W-1:0] q1_w [N];
    logic [W-1:0] q2_w [N];
    logic [W-1:0] o_w  [N];

    int n_chk  = 0;
    int n_fail = 0;

    logic [W-1:0] r_now, r_prev, f_now, f_prev;
    logic [W-1:0] snap1 [N];
    logic [W-1:0] snap2 [N];

    always #2.5 clk = ~clk;

    // instances 0..5: modes 0..5, reset value 0, asynchronous forcing
    // instances 6..11: modes 0..5, reset value 1, synchronous forcing
    for (genvar gi = 0; gi < N; gi++) begin : g_dut
        ioc_capture #(
            .WIDTH(W),
            .MODE(ioc_pkg::ioc_mode_e'(gi % 6)),
            .RESET_VAL(gi >= 6),
            .ASYNC_FORCE(gi < 6)
        ) dut_i (
            .clk(clk), .clk_en(clk_en), .rst_req(rst_req), .inv_req(inv_req), .din(din),
            .cap_rise(q1_w[gi]), .cap_fall(q2_w[gi]), .din_thru(o_w[gi])
        );
    end

    task automatic chk(input string req, input int idx, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s inst%0d %s act=%h exp=%h", req, idx, what, act, exp);
        end
    endtask

    function automatic logic [W-1:0] rst_pat(int i);
        return (i >= 6) ? {W{1'b1}} : {W{1'b0}};
    endfunction

    function automatic string mode_req(int m);
        case (m)
            0: return "R1";
            1: return "R3";
            2: return "R4";
            3: return "R5";
            4: return "R6";
            default: return "R7";
        endcase
    endfunction

    function automatic logic [W-1:0] exp_q1(int i, bit fall_pt);
        case (i % 6)
            0: return r_now;
            1: return fall_pt ? f_now : r_now;
            2: return rst_pat(i);
            3, 4: return r_now;
            default: return r_prev;
        endcase
    endfunction

    function automatic logic [W-1:0] exp_q2(int i, bit fall_pt);
        case (i % 6)
            0, 1, 2: return rst_pat(i);
            3: return f_now;
            default: return fall_pt ? f_prev : f_now;
        endcase
    endfunction

    task automatic check_point(input int kind, input bit fall_pt, input string tag);
        for (int i = 0; i < N; i++) begin
            chk("R4", i, "din_thru", o_w[i], din);
            if (kind == 1) begin
                chk({mode_req(i % 6), tag}, i, "cap_rise", q1_w[i], exp_q1(i, fall_pt));
                chk({mode_req(i % 6), tag}, i, "cap_fall", q2_w[i], exp_q2(i, fall_pt));
            end else if (kind == 2) begin
                chk("R2", i, "cap_rise hold", q1_w[i], snap1[i]);
                chk("R2", i, "cap_fall hold", q2_w[i], snap2[i]);
            end
        end
    endtask

    // kind: 0 no checks, 1 model checks, 2 hold checks; returns mid low phase
    task automatic cycle(input int kind, input string tag);
        @(posedge clk);
        r_prev = r_now;
        r_now  = din;
        #0.6;
        check_point(kind, 1'b0, tag);
        #0.65;
        din = W'($urandom);
        #0.1;
        if (kind == 1) begin
            for (int i = 0; i < N; i++)
                if (i % 6 == 1) chk("R3", i, "transparent", q1_w[i], din);
        end
        @(negedge clk);
        f_prev = f_now;
        f_now  = din;
        #0.6;
        check_point(kind, 1'b1, tag);
        #0.65;
        din = W'($urandom);
    endtask

    task automatic take_snap();
        for (int i = 0; i < N; i++) begin
            snap1[i] = q1_w[i];
            snap2[i] = q2_w[i];
        end
    endtask

    function automatic logic [W-1:0] forced_q2(int i, logic [W-1:0] fv);
        return (i % 6 >= 3) ? fv : rst_pat(i);
    endfunction

    // apply one request pair and check async-immediate, sync-deferred behaviour
    task automatic apply_force(input logic s, input logic v, input string req);
        logic [W-1:0] fv;
        take_snap();
        rst_req = s;
        inv_req = v;
        #0.1;
        for (int i = 0; i < N; i++) begin
            fv = s ? rst_pat(i) : ~rst_pat(i);
            if (i % 6 == 2) fv = rst_pat(i);
            if (i < 6) begin
                chk({req, " R11"}, i, "cap_rise async", q1_w[i], fv);
                chk({req, " R11"}, i, "cap_fall async", q2_w[i], forced_q2(i, fv));
            end else begin
                chk("R10", i, "cap_rise before edge", q1_w[i], snap1[i]);
                chk("R10", i, "cap_fall before edge", q2_w[i], snap2[i]);
            end
        end
        cycle(0, "");
        cycle(0, "");
        for (int i = 0; i < N; i++) begin
            fv = s ? rst_pat(i) : ~rst_pat(i);
            if (i % 6 == 2) fv = rst_pat(i);
            chk({req, " R10"}, i, "cap_rise forced", q1_w[i], fv);
            chk({req, " R10"}, i, "cap_fall forced", q2_w[i], forced_q2(i, fv));
        end
    endtask

    initial begin
        clk_en  = 1'b1;
        rst_req = 1'b1;
        inv_req = 1'b0;
        din     = '0;
        r_now = '0; r_prev = '0; f_now = '0; f_prev = '0;

        // reset state
        cycle(0, "");
        cycle(0, "");
        for (int i = 0; i < N; i++) begin
            chk("R8", i, "reset cap_rise", q1_w[i], rst_pat(i));
            chk("R8", i, "reset cap_fall", q2_w[i], rst_pat(i));
        end
        rst_req = 1'b0;

        // free-running capture in every mode
        cycle(0, "");
        cycle(0, "");
        for (int k = 0; k < 24; k++) cycle(1, "");

        // enable low: all storage holds
        take_snap();
        clk_en = 1'b0;
        for (int k = 0; k < 4; k++) cycle(2, "");
        clk_en = 1'b1;
        cycle(0, "");
        cycle(0, "");
        for (int k = 0; k < 6; k++) cycle(1, " after enable");

        // forcing sequence: inverse only, both, reset only
        apply_force(1'b0, 1'b1, "R9");
        apply_force(1'b1, 1'b1, "R9");
        apply_force(1'b1, 1'b0, "R8");

        // release and resume
        rst_req = 1'b0;
        inv_req = 1'b0;
        cycle(0, "");
        cycle(0, "");
        for (int k = 0; k < 12; k++) cycle(1, " R12");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #100000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog act=running exp=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule